// File: doc/BRIEF.md
# RTS Throttle and Flush Pulse Generator

This block drives an active-low request-to-send line for a serial link. It compares the fill count of a receive buffer against two programmable levels and deasserts permission to send (drives `rts_n` high) when the buffer gets too full. Permission returns only once the buffer has drained to a lower level, so the line does not chatter around one threshold.

The block can also emit a timed flush pulse. When a packet has ended and flushing is enabled, the block waits a programmable number of cycles and then forces `rts_n` high for a programmable number of cycles. A single 16-bit configuration word, written in one cycle, sets both thresholds, the flush enable, the pulse width and the pulse delay. The buffer and the serial port sit outside the block.

Top module: `rts_flow_ctl`

## Requirements
- R1: After reset the configuration is all zero, no flush is pending and `rts_n` is low, whatever the fill count.
- R2: A cycle with `cfg_wr` high loads `cfg_word` as follows: bit 12 flush enable, bits [11:9] pulse width, bits [8:6] pulse delay, bits [5:3] off level, bits [2:0] on level. The new values govern behaviour from the following cycle. While `cfg_wr` is low, `cfg_word` has no effect.
- R3: An off level of 0 disables level throttling, so `fill_cnt` alone never drives `rts_n` high.
- R4: With a non-zero off level, a fill count at or above the off level drives `rts_n` high after the next clock edge.
- R5: Once throttled, `rts_n` stays high while the fill count is above the on level. It returns low after the first clock edge that sees the fill count at or below the on level.
- R6: With flush enabled, an `eop_evt` sampled at edge e drives `rts_n` high after edges e+D through e+D+W-1, where D is the delay field and W is the width field.
- R7: An `eop_evt` that arrives while the delay is still running restarts the delay from that edge.
- R8: `eop_evt` has no effect when flush is disabled. It also has no effect while a pulse is in progress: the pulse neither stretches nor repeats.
- R9: A width or delay field of 0 acts as 1.
- R10: `rts_n` is high whenever level throttling or the flush pulse asks for it. A pulse that ends while throttling is active leaves `rts_n` high.
- R11: A configuration write that clears the flush enable cancels a pending flush. No pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_word | input | 16 | Packed configuration word |
| fill_cnt | input | FILL_W | Receive buffer fill count |
| eop_evt | input | 1 | End-of-packet event, one cycle per packet |
| rts_n | output | 1 | Active-low request to send |

## Verification
The bench walks the fill count across the space between the two levels, both rising and falling. A design without hysteresis would drop `rts_n` as soon as the count fell below the off level. It runs flush pulses with minimum, medium and maximum width and delay. An off-by-one counter would show up there as a pulse shifted or stretched by a cycle. Zero-valued fields, a second packet end during the delay and a packet end during the pulse check restart and ignore behaviour. A design that kept counting would fire early, one that re-armed would emit a second pulse, and one that treated zero literally would wrap to a long pulse. A disable written during the delay must cancel the pulse. A design that only gated the start of a flush would still fire.

// File: rtl/rts_pkg.sv
package rts_pkg;

    parameter int unsigned CFG_W   = 16;
    parameter int unsigned FIELD_W = 3;

    localparam int unsigned ON_LSB  = 0;
    localparam int unsigned OFF_LSB = ON_LSB + FIELD_W;
    localparam int unsigned DLY_LSB = OFF_LSB + FIELD_W;
    localparam int unsigned WID_LSB = DLY_LSB + FIELD_W;
    localparam int unsigned EN_BIT  = WID_LSB + FIELD_W;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        logic   flush_en;
        field_t width;
        field_t delay;
        field_t off_lvl;
        field_t on_lvl;
    } rts_cfg_t;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_WAIT  = 2'd1,
        FL_PULSE = 2'd2
    } fl_state_e;

    function automatic rts_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        rts_cfg_t c;
        c.flush_en = w[EN_BIT];
        c.width    = w[WID_LSB +: FIELD_W];
        c.delay    = w[DLY_LSB +: FIELD_W];
        c.off_lvl  = w[OFF_LSB +: FIELD_W];
        c.on_lvl   = w[ON_LSB  +: FIELD_W];
        return c;
    endfunction

    function automatic field_t at_least_one(input field_t v);
        return (v == '0) ? field_t'(1) : v;
    endfunction

endpackage

// File: rtl/rts_cfg_reg.sv
module rts_cfg_reg
    import rts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] word,
    output rts_cfg_t         cfg
);

    rts_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d = unpack_cfg(word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cfg_q));

endmodule

// File: rtl/rts_level_ctl.sv
module rts_level_ctl
    import rts_pkg::*;
#(
    parameter int unsigned FILL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill,
    input  field_t            off_lvl,
    input  field_t            on_lvl,
    output logic              throttle
);

    localparam int unsigned PAD_W = FILL_W - FIELD_W;

    typedef struct packed {
        logic thr;
    } lvl_reg_t;

    lvl_reg_t lv_d, lv_q;

    logic [FILL_W-1:0] off_ext, on_ext;
    logic              above_off, below_on, lvl_active;

    assign off_ext    = {{PAD_W{1'b0}}, off_lvl};
    assign on_ext     = {{PAD_W{1'b0}}, on_lvl};
    assign lvl_active = (off_lvl != '0);
    assign above_off  = lvl_active && (fill >= off_ext);
    assign below_on   = (fill <= on_ext);

    always_comb begin
        lv_d = lv_q;
        if (!lvl_active) begin
            lv_d.thr = 1'b0;
        end else if (above_off) begin
            lv_d.thr = 1'b1;
        end else if (below_on) begin
            lv_d.thr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lv_q <= '0;
        end else begin
            lv_q <= lv_d;
        end
    end

    assign throttle = lv_q.thr;

    // R3
    lvl_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_lvl == '0) |=> !lv_q.thr);

    // R4
    thr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lv_q.thr) |-> $past(fill >= off_ext));

    // R5
    thr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lv_q.thr) |-> ($past(fill <= on_ext) || $past(off_lvl == '0)));

endmodule

// File: rtl/rts_flush_gen.sv
module rts_flush_gen
    import rts_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  field_t width,
    input  field_t delay,
    input  logic   eop,
    output logic   pulse
);

    typedef struct packed {
        fl_state_e st;
        field_t    cnt;
    } fl_reg_t;

    fl_reg_t fl_d, fl_q;
    field_t  eff_w, eff_d;

    assign eff_w = at_least_one(width);
    assign eff_d = at_least_one(delay);

    always_comb begin
        fl_d = fl_q;
        if (!en) begin
            fl_d.st  = FL_IDLE;
            fl_d.cnt = '0;
        end else begin
            unique case (fl_q.st)
                FL_IDLE: begin
                    if (eop) begin
                        fl_d.st  = FL_WAIT;
                        fl_d.cnt = eff_d;
                    end
                end
                FL_WAIT: begin
                    if (eop) begin
                        fl_d.cnt = eff_d;
                    end else if (fl_q.cnt <= field_t'(1)) begin
                        fl_d.st  = FL_PULSE;
                        fl_d.cnt = eff_w;
                    end else begin
                        fl_d.cnt = fl_q.cnt - field_t'(1);
                    end
                end
                FL_PULSE: begin
                    if (fl_q.cnt <= field_t'(1)) begin
                        fl_d.st  = FL_IDLE;
                        fl_d.cnt = '0;
                    end else begin
                        fl_d.cnt = fl_q.cnt - field_t'(1);
                    end
                end
                default: begin
                    fl_d.st  = FL_IDLE;
                    fl_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '{st: FL_IDLE, cnt: '0};
        end else begin
            fl_q <= fl_d;
        end
    end

    assign pulse = (fl_q.st == FL_PULSE);

    // R6
    pulse_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> ($past(fl_q.st) == FL_WAIT));

    // R8
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (fl_q.st == FL_IDLE));

    // R9
    pulse_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.st == FL_PULSE) |-> (fl_q.cnt != '0));

    // R7
    wait_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && eop && fl_q.st == FL_WAIT) |=> (fl_q.st == FL_WAIT));

endmodule

// File: rtl/rts_flow_ctl.sv
module rts_flow_ctl
    import rts_pkg::*;
#(
    parameter int unsigned FILL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [15:0]       cfg_word,
    input  logic [FILL_W-1:0] fill_cnt,
    input  logic              eop_evt,
    output logic              rts_n
);

    rts_cfg_t cfg;
    logic     lvl_thr;
    logic     fl_pulse;

    rts_cfg_reg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .word  (cfg_word),
        .cfg   (cfg)
    );

    rts_level_ctl #(.FILL_W(FILL_W)) i_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill     (fill_cnt),
        .off_lvl  (cfg.off_lvl),
        .on_lvl   (cfg.on_lvl),
        .throttle (lvl_thr)
    );

    rts_flush_gen i_flush (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg.flush_en),
        .width (cfg.width),
        .delay (cfg.delay),
        .eop   (eop_evt),
        .pulse (fl_pulse)
    );

    assign rts_n = lvl_thr | fl_pulse;

    // R1
    reset_low_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !rts_n);

endmodule

// File: tb/test_rts_flow_ctl.sv
`timescale 1ns/1ps
module test_rts_flow_ctl;

    localparam int FILL_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [15:0]       cfg_word = '0;
    logic [FILL_W-1:0] fill_cnt = '0;
    logic              eop_evt = 1'b0;
    logic              rts_n;

    always #2 clk = ~clk;

    rts_flow_ctl #(.FILL_W(FILL_W)) i_rts_flow_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .fill_cnt(fill_cnt), .eop_evt(eop_evt), .rts_n(rts_n)
    );

    typedef struct {
        logic  exp;
        string tag;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic lvl_exp = 1'b0;

    // Monitor: compares rts_n one time unit after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            cur = sb.pop_front();
            checks++;
            if (rts_n !== cur.exp) begin
                errors++;
                $display("FAIL %s: rts_n=%0b expected=%0b at %0t", cur.tag, rts_n, cur.exp, $time);
            end
        end
    end

    // Driver: applies one cycle of stimulus and queues the value expected after the edge.
    task automatic drv(input logic [FILL_W-1:0] f, input logic ev, input logic wr,
                       input logic [15:0] w, input logic exp, input string tag);
        fill_cnt = f;
        eop_evt  = ev;
        cfg_wr   = wr;
        cfg_word = w;
        sb.push_back('{exp: exp, tag: tag});
        @(negedge clk);
    endtask

    task automatic load_cfg(input logic [15:0] w);
        drv('0, 1'b0, 1'b1, w, 1'b0, "R2");
        drv('0, 1'b0, 1'b0, 16'h0, 1'b0, "R2");
        lvl_exp = 1'b0;
    endtask

    // Expected throttle from R3/R4/R5.
    task automatic lvl_step(input int f, input int off, input int on, input string tag);
        if (off == 0)      lvl_exp = 1'b0;
        else if (f >= off) lvl_exp = 1'b1;
        else if (f <= on)  lvl_exp = 1'b0;
        drv(FILL_W'(f), 1'b0, 1'b0, 16'hFFFF, lvl_exp, tag);
    endtask

    // Expected flush pulse from R6: high for D <= j < D+W.
    task automatic flush_run(input int d, input int w, input string tag);
        drv('0, 1'b1, 1'b0, '0, 1'b0, tag);
        for (int j = 1; j <= d + w + 1; j++) begin
            drv('0, 1'b0, 1'b0, '0, (j >= d && j < d + w), tag);
        end
    endtask

    function automatic logic [15:0] mk(input int en, input int w, input int d,
                                       input int off, input int on);
        return 16'((en << 12) | (w << 9) | (d << 6) | (off << 3) | on);
    endfunction

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, even with a large fill and packet ends
        drv('0, 1'b0, 1'b0, '0, 1'b0, "R1");
        drv(6'd7, 1'b1, 1'b0, '0, 1'b0, "R1");
        drv(6'd7, 1'b0, 1'b0, '0, 1'b0, "R1");
        drv(6'd7, 1'b0, 1'b0, '0, 1'b0, "R1");
        drv('0, 1'b0, 1'b0, '0, 1'b0, "R1");

        // R4/R5: off=1, on=0; burst fill up to 8 then drain
        load_cfg(mk(0, 0, 0, 1, 0));
        for (int i = 0; i <= 8; i++) lvl_step(i, 1, 0, "R4");
        for (int i = 7; i >= 0; i--) lvl_step(i, 1, 0, "R5");

        // R5 hysteresis off=5 on=2; cfg_word garbage with cfg_wr low (R2)
        load_cfg(mk(0, 0, 0, 5, 2));
        lvl_step(0, 5, 2, "R2");
        lvl_step(3, 5, 2, "R5");
        lvl_step(4, 5, 2, "R5");
        lvl_step(5, 5, 2, "R4");
        lvl_step(6, 5, 2, "R4");
        lvl_step(4, 5, 2, "R5");
        lvl_step(3, 5, 2, "R5");
        lvl_step(2, 5, 2, "R5");
        lvl_step(1, 5, 2, "R5");
        lvl_step(3, 5, 2, "R5");
        lvl_step(4, 5, 2, "R5");
        lvl_step(63, 5, 2, "R4");
        lvl_step(0, 5, 2, "R5");

        // R3: off level 0 disables throttle
        load_cfg(mk(0, 0, 0, 0, 3));
        lvl_step(40, 0, 3, "R3");
        lvl_step(63, 0, 3, "R3");
        lvl_step(0, 0, 3, "R3");

        // R6: pulse shapes
        load_cfg(mk(1, 1, 1, 0, 0));
        flush_run(1, 1, "R6");
        load_cfg(mk(1, 3, 1, 0, 0));
        flush_run(1, 3, "R6");
        load_cfg(mk(1, 7, 7, 0, 0));
        flush_run(7, 7, "R6");

        // R9: zero fields act as one
        load_cfg(mk(1, 0, 0, 0, 0));
        flush_run(1, 1, "R9");

        // R7: restart during delay, D=4 W=2
        load_cfg(mk(1, 2, 4, 0, 0));
        drv('0, 1'b1, 1'b0, '0, 1'b0, "R7");
        drv('0, 1'b0, 1'b0, '0, 1'b0, "R7");
        drv('0, 1'b0, 1'b0, '0, 1'b0, "R7");
        drv('0, 1'b1, 1'b0, '0, 1'b0, "R7");
        for (int j = 1; j <= 7; j++) drv('0, 1'b0, 1'b0, '0, (j >= 4 && j < 6), "R7");

        // R8: eop during pulse ignored, D=1 W=4
        load_cfg(mk(1, 4, 1, 0, 0));
        drv('0, 1'b1, 1'b0, '0, 1'b0, "R8");
        drv('0, 1'b0, 1'b0, '0, 1'b1, "R8");
        drv('0, 1'b1, 1'b0, '0, 1'b1, "R8");
        for (int j = 3; j <= 9; j++) drv('0, 1'b0, 1'b0, '0, (j <= 4), "R8");

        // R8: flush disabled ignores eop
        load_cfg(mk(0, 2, 1, 0, 0));
        drv('0, 1'b1, 1'b0, '0, 1'b0, "R8");
        for (int j = 1; j <= 6; j++) drv('0, 1'b0, 1'b0, '0, 1'b0, "R8");

        // R10: throttle and pulse combine, off=3 on=1 D=2 W=2
        load_cfg(mk(1, 2, 2, 3, 1));
        drv(6'd4, 1'b0, 1'b0, '0, 1'b1, "R10");
        drv(6'd4, 1'b1, 1'b0, '0, 1'b1, "R10");
        for (int j = 1; j <= 5; j++) drv(6'd4, 1'b0, 1'b0, '0, 1'b1, "R10");
        drv(6'd0, 1'b0, 1'b0, '0, 1'b0, "R10");
        drv(6'd2, 1'b1, 1'b0, '0, 1'b0, "R10");
        for (int j = 1; j <= 5; j++) drv(6'd2, 1'b0, 1'b0, '0, (j >= 2 && j < 4), "R10");

        // R11: disabling during delay cancels, D=5 W=2
        load_cfg(mk(1, 2, 5, 0, 0));
        drv('0, 1'b1, 1'b0, '0, 1'b0, "R11");
        drv('0, 1'b0, 1'b0, '0, 1'b0, "R11");
        drv('0, 1'b0, 1'b1, mk(0, 2, 5, 0, 0), 1'b0, "R11");
        for (int j = 3; j <= 10; j++) drv('0, 1'b0, 1'b0, '0, 1'b0, "R11");

        @(posedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule